// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block schedules and times analog-to-digital conversions for three channels: external input 1, external input 2 and an on-chip temperature sensor. Software sets one or more start bits in a control register. The sequencer then runs the requested conversions one after another. Each conversion uses the resolution code and clock-divider code held in that channel's configuration register.

For each conversion, the block derives a converter clock tick from the system clock and counts the number of converter clocks that the chosen resolution requires. At the end it captures the converter's result, left-justifies it into the channel's data register and clears that channel's start bit. A processor stall output stays high as long as any start bit is pending. The analog converter is outside the block: it supplies a right-justified raw value on `adc_raw` and sees the active channel on `conv_chan`. The gain, bias and input-select fields are only stored and passed on.

Top module: `adc_seq_top`

## Requirements
- R1: After synchronous reset every readable register (addresses 0h to Fh) reads zero, and `cpu_halt`, `conv_busy`, `conv_tick` and `in_sel` are low.
- R2: A write to the control register (address 0h) stores the start bits [2:0] and the input select [11:8]. `in_sel` shows the select field. All other control bits read back as zero.
- R3: `cpu_halt` is high in every cycle in which any start bit is set, including the idle cycle between back-to-back conversions, and is low once all start bits have cleared.
- R4: A conversion ends, and its data register updates, exactly 1 + N·SYS_DIV·2^D clock edges after the edge that accepted the control write. N is the converter-clock count for the resolution and D is the divider code. A queued conversion starts on the edge after the previous one ends.
- R5: Configuration bits [14:12] hold the resolution code. Codes 0 to 6 select 9, 10, 12, 13, 14, 15 and 16 bits, and need 256, 320, 512, 640, 800, 1280 and 2048 converter clocks. Code 7 behaves exactly like code 6.
- R6: Configuration bits [2:0] hold the divider code D. While converting, `conv_tick` pulses once every SYS_DIV·2^D cycles, and the first pulse comes SYS_DIV·2^D cycles after the conversion starts.
- R7: The stored result is the low B bits of `adc_raw` (B = resolution in bits), shifted so that its MSB sits at bit 15, with zeros below. `adc_raw` is sampled in the last cycle of the conversion.
- R8: Results go to address 1h for input 1, 4h for input 2 and 7h for temperature. The other data registers are unchanged.
- R9: Start bit 2 requests input 1, bit 1 requests input 2 and bit 0 requests temperature. Pending requests run one at a time in the order input 1, input 2, temperature.
- R10: Configuration registers are at addresses 2h, 5h and 8h and read back as written. A configuration write during a conversion does not change the timing or the result of that conversion.
- R11: Data registers cannot be changed by writes.
- R12: When a conversion ends, only that channel's start bit clears. The other pending start bits stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| adc_raw | input | 16 | Right-justified raw result from the converter model |
| in_sel | output | 4 | Single-ended input select field |
| conv_busy | output | 1 | A conversion is in progress |
| conv_chan | output | 2 | Active channel: 0 input 1, 1 input 2, 2 temperature |
| conv_tick | output | 1 | Converter clock tick |
| cpu_halt | output | 1 | Processor stall request |

## Verification
The embedded assertions check several rules on every cycle. The spacing of converter ticks must equal the divided period. A busy sequencer must also be stalling the processor. The highest-priority pending channel must be chosen at start. The latched setting must stay fixed during a conversion. A data register may change only at its own channel's completion. A finished channel's start bit must be clear afterwards. Only the bench scenarios can show exact completion cycles, the resolution-to-clock-count table, the handling of the reserved code, the left-justified values, the order of a three-channel batch, and that configuration writes made mid-conversion leave that conversion unchanged.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 4;
    localparam int NCH     = 3;
    localparam int RES_W   = 3;
    localparam int DIV_W   = 3;
    localparam int TCNT_W  = 11;
    localparam int RES_LSB = 12;
    localparam int DIV_LSB = 0;
    localparam int SEL_LSB = 8;
    localparam int SEL_W   = 4;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = '0;

    typedef enum logic {ST_IDLE, ST_CONV} seq_state_e;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [DIV_W-1:0] div;
    } conv_set_t;

    // channel c: data at 3c+1, configuration at 3c+2
    function automatic logic [ADDR_W-1:0] data_addr(int ch);
        return ADDR_W'(3 * ch + 1);
    endfunction

    function automatic logic [ADDR_W-1:0] cfg_addr(int ch);
        return ADDR_W'(3 * ch + 2);
    endfunction

    // channel 0 owns the top start bit
    function automatic int start_idx(int ch);
        return NCH - 1 - ch;
    endfunction

    function automatic logic [RES_W-1:0] res_clamp(logic [RES_W-1:0] code);
        return (code == 3'b111) ? 3'b110 : code;
    endfunction

    // converter clocks per conversion, minus one
    function automatic logic [TCNT_W-1:0] res_last_tick(logic [RES_W-1:0] code);
        case (code)
            3'd0:    return TCNT_W'(255);
            3'd1:    return TCNT_W'(319);
            3'd2:    return TCNT_W'(511);
            3'd3:    return TCNT_W'(639);
            3'd4:    return TCNT_W'(799);
            3'd5:    return TCNT_W'(1279);
            default: return TCNT_W'(2047);
        endcase
    endfunction

    // 16 minus the resolution in bits
    function automatic logic [3:0] res_shift(logic [RES_W-1:0] code);
        case (code)
            3'd0:    return 4'd7;
            3'd1:    return 4'd6;
            3'd2:    return 4'd4;
            3'd3:    return 4'd3;
            3'd4:    return 4'd2;
            3'd5:    return 4'd1;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] left_justify(logic [DATA_W-1:0] raw,
                                                       logic [RES_W-1:0] code);
        return raw << res_shift(code);
    endfunction
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
    import adc_seq_pkg::*;
#(
    parameter int SYS_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);
    localparam int PRE_W = $clog2(SYS_DIV) + (1 << DIV_W) - 1;

    logic [PRE_W:0]   period;
    logic [PRE_W-1:0] reload;
    logic [PRE_W-1:0] pre_q;

    assign period = (PRE_W + 1)'(SYS_DIV) << div_code;
    assign reload = PRE_W'(period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (load) begin
            pre_q <= reload;
        end else if (run) begin
            pre_q <= (pre_q == '0) ? reload : pre_q - 1'b1;
        end
    end

    assign tick = run && (pre_q == '0);

    // independent cycle counter used only to check tick spacing
    logic [PRE_W:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst || load) begin
            gap_q <= '0;
        end else if (run) begin
            gap_q <= tick ? '0 : gap_q + 1'b1;
        end
    end

    p_tick_period_r6: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap_q == period - 1'b1))
        else $error("converter tick spacing differs from divided period");
endmodule

// File: rtl/adc_conv_ctl.sv
module adc_conv_ctl
    import adc_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        start_req,
    input  conv_set_t [NCH-1:0]   cfg_set,
    input  logic [DATA_W-1:0]     adc_raw,
    input  logic                  tick,
    output logic                  busy,
    output logic [1:0]            chan,
    output logic                  load,
    output logic [DIV_W-1:0]      div_sel,
    output logic                  done,
    output logic [1:0]            done_chan,
    output logic [DATA_W-1:0]     result
);
    seq_state_e        state_q;
    logic [1:0]        chan_q;
    conv_set_t         set_q;
    logic [TCNT_W-1:0] cnt_q;

    logic [1:0] pick;
    conv_set_t  pick_set;
    logic       accept;

    // lowest channel number wins
    always_comb begin
        pick = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (start_req[start_idx(c)]) pick = 2'(c);
        end
        pick_set     = cfg_set[pick];
        pick_set.res = res_clamp(pick_set.res);
    end

    assign accept = (state_q == ST_IDLE) && (|start_req);
    assign done   = (state_q == ST_CONV) && tick && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
            set_q   <= '0;
            cnt_q   <= '0;
        end else if (accept) begin
            state_q <= ST_CONV;
            chan_q  <= pick;
            set_q   <= pick_set;
            cnt_q   <= res_last_tick(pick_set.res);
        end else if (done) begin
            state_q <= ST_IDLE;
        end else if ((state_q == ST_CONV) && tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy      = (state_q == ST_CONV);
    assign chan      = chan_q;
    assign load      = accept;
    assign div_sel   = accept ? pick_set.div : set_q.div;
    assign done_chan = chan_q;
    assign result    = left_justify(adc_raw, set_q.res);

    p_first_pick_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_req[NCH-1]) |=> (state_q == ST_CONV && chan_q == 2'd0))
        else $error("input 1 request not served first");

    p_second_pick_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !start_req[NCH-1] && start_req[NCH-2])
            |=> (state_q == ST_CONV && chan_q == 2'd1))
        else $error("input 2 request not served before temperature");

    p_hold_setting_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && $past(state_q == ST_CONV)) |-> ($stable(set_q) && $stable(chan_q)))
        else $error("conversion setting changed mid-conversion");
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                done,
    input  logic [1:0]          done_chan,
    input  logic [DATA_W-1:0]   result,
    output logic [NCH-1:0]      start_req,
    output logic [SEL_W-1:0]    sel,
    output conv_set_t [NCH-1:0] cfg_set
);
    logic [NCH-1:0]    start_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] cfg_q  [NCH];
    logic [DATA_W-1:0] data_q [NCH];

    logic           ctrl_wr;
    logic [NCH-1:0] start_next;
    logic [NCH-1:0] clear_mask;

    assign ctrl_wr    = wr_en && (wr_addr == ADDR_CTRL);
    assign start_next = ctrl_wr ? wr_data[NCH-1:0] : start_q;
    assign clear_mask = done ? (NCH'(1) << start_idx(int'(done_chan))) : '0;

    // completion clear has priority over a simultaneous write
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            sel_q   <= '0;
        end else begin
            start_q <= start_next & ~clear_mask;
            if (ctrl_wr) sel_q <= wr_data[SEL_LSB +: SEL_W];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
            end else if (wr_en && (wr_addr == cfg_addr(g))) begin
                cfg_q[g] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[g] <= '0;
            end else if (done && (done_chan == 2'(g))) begin
                data_q[g] <= result;
            end
        end

        assign cfg_set[g] = {cfg_q[g][RES_LSB +: RES_W], cfg_q[g][DIV_LSB +: DIV_W]};

        p_data_hold_r11: assert property (@(posedge clk) disable iff (rst)
            !(done && (done_chan == 2'(g))) |=> $stable(data_q[g]))
            else $error("data register changed outside its completion");
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CTRL) begin
            rd_data[SEL_LSB +: SEL_W] = sel_q;
            rd_data[NCH-1:0]          = start_q;
        end
        for (int c = 0; c < NCH; c++) begin
            if (rd_addr == data_addr(c)) rd_data = data_q[c];
            if (rd_addr == cfg_addr(c))  rd_data = cfg_q[c];
        end
    end

    assign start_req = start_q;
    assign sel       = sel_q;

    p_clear_done_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> ((start_q & $past(clear_mask)) == '0))
        else $error("finished channel start bit still set");
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int SYS_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] adc_raw,
    output logic [SEL_W-1:0]  in_sel,
    output logic              conv_busy,
    output logic [1:0]        conv_chan,
    output logic              conv_tick,
    output logic              cpu_halt
);
    logic [NCH-1:0]     start_req;
    conv_set_t [NCH-1:0] cfg_set;
    logic               load;
    logic [DIV_W-1:0]   div_sel;
    logic               done;
    logic [1:0]         done_chan;
    logic [DATA_W-1:0]  result;

    adc_seq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .done      (done),
        .done_chan (done_chan),
        .result    (result),
        .start_req (start_req),
        .sel       (in_sel),
        .cfg_set   (cfg_set)
    );

    adc_conv_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .cfg_set   (cfg_set),
        .adc_raw   (adc_raw),
        .tick      (conv_tick),
        .busy      (conv_busy),
        .chan      (conv_chan),
        .load      (load),
        .div_sel   (div_sel),
        .done      (done),
        .done_chan (done_chan),
        .result    (result)
    );

    adc_tick_gen #(.SYS_DIV(SYS_DIV)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .run      (conv_busy),
        .div_code (div_sel),
        .tick     (conv_tick)
    );

    assign cpu_halt = |start_req;

    p_busy_halts_r3: assert property (@(posedge clk) disable iff (rst)
        conv_busy |-> cpu_halt)
        else $error("conversion running without processor stall");
endmodule

// File: tb/adc_seq_top_bench.sv
module adc_seq_top_bench;
    localparam int TB_SYS_DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr;
    logic [15:0] rd_data;
    logic [15:0] adc_raw;
    logic [3:0]  in_sel;
    logic        conv_busy;
    logic [1:0]  conv_chan;
    logic        conv_tick;
    logic        cpu_halt;

    always #5 clk = ~clk;

    adc_seq_top #(.SYS_DIV(TB_SYS_DIV)) u_adc_seq_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .adc_raw(adc_raw), .in_sel(in_sel),
        .conv_busy(conv_busy), .conv_chan(conv_chan), .conv_tick(conv_tick),
        .cpu_halt(cpu_halt)
    );

    int     checks = 0;
    int     fails  = 0;
    longint cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [15:0] raw_val [3];
    assign adc_raw = (conv_chan < 2'd3) ? raw_val[conv_chan] : 16'h0;

    logic [3:0] main_addr = '0;
    logic [3:0] mon_addr  = '0;
    logic       mon_active = 1'b0;
    assign rd_addr = mon_active ? mon_addr : main_addr;

    int clk_tab  [8] = '{256, 320, 512, 640, 800, 1280, 2048, 2048};
    int bits_tab [8] = '{9, 10, 12, 13, 14, 15, 16, 16};
    int res_of [3];
    int div_of [3];
    longint last_due;

    typedef struct {
        int          ch;
        longint      due;
        logic [15:0] val;
        logic [2:0]  rest;
        int          ticks;
    } exp_t;
    exp_t q[$];

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        main_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_cfg(input int ch, input int res, input int dv);
        res_of[ch] = res;
        div_of[ch] = dv;
        wr(4'(3 * ch + 2), 16'((res << 12) | 16'h0500 | dv));
    endtask

    function automatic logic [15:0] lj(input logic [15:0] raw, input int res);
        int b;
        b = bits_tab[res];
        return 16'(((int'(raw)) & ((1 << b) - 1)) << (16 - b));
    endfunction

    // driver: queue expected completions, then write the control register
    task automatic launch(input logic [3:0] sel, input logic [2:0] mask);
        longint prev;
        logic [2:0] rest;
        @(negedge clk);
        prev = cyc + 1;
        rest = mask;
        for (int ch = 0; ch < 3; ch++) begin
            if (mask[2 - ch]) begin
                exp_t e;
                int   len;
                len = clk_tab[res_of[ch]] * TB_SYS_DIV * (1 << div_of[ch]);
                rest[2 - ch] = 1'b0;
                e.ch = ch;
                e.due = prev + 1 + len;
                e.val = lj(raw_val[ch], res_of[ch]);
                e.rest = rest;
                e.ticks = clk_tab[res_of[ch]];
                q.push_back(e);
                prev = e.due;
            end
        end
        last_due = prev;
        wr_en = 1'b1; wr_addr = 4'h0; wr_data = {4'h0, sel, 5'h00, mask};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (q.size() != 0 || conv_busy || cpu_halt);
        @(negedge clk);
    endtask

    // monitor: on each end of conversion pop and compare
    int         tick_cnt = 0;
    int         tick_base = 0;
    logic       was_busy = 1'b0;
    logic [1:0] last_chan = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (conv_tick) tick_cnt++;
            if (was_busy && !conv_busy) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8 unexpected completion", last_chan, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(last_chan == 2'(e.ch), "R9 channel order", last_chan, e.ch);
                    check(cyc == e.due, "R4 completion cycle", cyc, e.due);
                    check(tick_cnt - tick_base == e.ticks, "R5 converter clocks per conversion",
                          tick_cnt - tick_base, e.ticks);
                    mon_active = 1'b1;
                    mon_addr = 4'(3 * e.ch + 1);
                    #1;
                    check(rd_data == e.val, "R7 R8 left-justified result", rd_data, e.val);
                    mon_addr = 4'h0;
                    #1;
                    check(rd_data[2:0] == e.rest, "R12 remaining start bits", rd_data[2:0], e.rest);
                    mon_active = 1'b0;
                end
                tick_base = tick_cnt;
            end
            was_busy = conv_busy;
            if (conv_busy) last_chan = conv_chan;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int k;
        int lows;
        for (int c = 0; c < 3; c++) raw_val[c] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check(d == 16'h0, "R1 register after reset", d, 0);
        end
        check(!cpu_halt && !conv_busy && !conv_tick, "R1 status after reset",
              {cpu_halt, conv_busy, conv_tick}, 0);
        check(in_sel == 4'h0, "R1 select after reset", in_sel, 0);

        // input 1, 9 bits, divider 0
        set_cfg(0, 0, 0);
        raw_val[0] = 16'h01A5;
        launch(4'h2, 3'b100);
        repeat (10) @(negedge clk);
        check(cpu_halt == 1'b1, "R3 halt while converting", cpu_halt, 1);
        check(conv_busy && conv_chan == 2'd0, "R9 input 1 active", conv_chan, 0);
        check(in_sel == 4'h2, "R2 select output", in_sel, 2);
        wait_idle();
        check(cpu_halt == 1'b0, "R3 halt released", cpu_halt, 0);
        rd(4'h4, d); check(d == 16'h0, "R8 input 2 data untouched", d, 0);
        rd(4'h7, d); check(d == 16'h0, "R8 temperature data untouched", d, 0);
        rd(4'h0, d); check(d == 16'h0200, "R2 control readback", d, 16'h0200);

        // R2 unused control bits
        wr(4'h0, 16'hF5F8);
        rd(4'h0, d); check(d == 16'h0500, "R2 unused bits read zero", d, 16'h0500);
        check(in_sel == 4'h5 && !cpu_halt, "R2 select without start", in_sel, 5);

        // input 2, 10 bits, divider 1, overflow bits dropped
        set_cfg(1, 1, 1);
        raw_val[1] = 16'hFFFF;
        launch(4'h0, 3'b010);
        wait_idle();

        // temperature, 16 bits
        set_cfg(2, 6, 0);
        raw_val[2] = 16'h1234;
        launch(4'h0, 3'b001);
        wait_idle();

        // R5 reserved code 7 behaves as 6
        set_cfg(2, 7, 0);
        raw_val[2] = 16'hABCD;
        launch(4'h0, 3'b001);
        wait_idle();

        // input 1, 15 bits, divider 2
        set_cfg(0, 5, 2);
        raw_val[0] = 16'h7FFF;
        launch(4'h0, 3'b100);
        wait_idle();

        // R9 all three requested together, R3 halt across gaps
        set_cfg(0, 2, 0); raw_val[0] = 16'h0FFF;
        set_cfg(1, 3, 0); raw_val[1] = 16'h1555;
        set_cfg(2, 4, 0); raw_val[2] = 16'h3FFF;
        launch(4'h0, 3'b111);
        lows = 0;
        while (cyc < last_due) begin
            if (!cpu_halt) lows++;
            @(negedge clk);
        end
        check(lows == 0, "R3 halt held through batch", lows, 0);
        wait_idle();

        // R6 tick period with divider 3
        set_cfg(1, 0, 3);
        raw_val[1] = 16'h0080;
        launch(4'h0, 3'b010);
        k = 0;
        while (!conv_tick) begin @(negedge clk); k++; end
        check(k == 32, "R6 first tick delay", k, 32);
        @(negedge clk);
        k = 1;
        while (!conv_tick) begin @(negedge clk); k++; end
        check(k == 32, "R6 tick spacing", k, 32);
        wait_idle();

        // R10 configuration write during a conversion
        set_cfg(0, 0, 0);
        raw_val[0] = 16'h0155;
        launch(4'h0, 3'b100);
        repeat (20) @(negedge clk);
        wr(4'h2, 16'h7007);
        wait_idle();
        rd(4'h2, d); check(d == 16'h7007, "R10 configuration readback", d, 16'h7007);

        // R11 data registers cannot be written
        wr(4'h1, 16'h5555);
        rd(4'h1, d); check(d == 16'hAA80, "R11 data write ignored", d, 16'hAA80);
        check(!cpu_halt && !conv_busy, "R11 no conversion from data write", conv_busy, 0);

        check(q.size() == 0, "R4 all conversions completed", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule